// File: doc/BRIEF.md
# Power-Good and Clock-Enable Supervisor

This block drives the two regulation status outputs of a multiphase voltage regulator controller: an active-low clock-enable and an open-drain power-good. The open-drain pin is represented by `pg_release_o`, where 1 means the pin is released and 0 means it is pulled low. The sequencer reports the controller phase on `phase_i`. The slew-rate controller reports whether a voltage transition is in progress and which way it is going. Two window comparators report whether the feedback voltage is above the lower limit and below the upper limit.

Outside the forced periods, both outputs follow the regulation window, and clock-enable is the inverse of power-good. Several conditions override this:

- The ramp and shutdown phases force both outputs inactive.
- Power-good waits a startup delay before it begins to monitor.
- A voltage transition forces clock-enable low and releases power-good, both for the duration of the transition and for a hold time after it.
- A downward transition made while the converter is in pulse-skipping mode masks the upper comparator. The mask stays in place until the output has settled back into the window.

The block is built around a state machine with seven states:

| State | When it is entered | clk_en_n_o | pg_release_o |
|---|---|---|---|
| ST_OFF | off phase, or an unused phase code | 1 | 0 |
| ST_SOFTSTART | soft-start phase | 1 | 0 |
| ST_BOOT | boot phase | not in regulation | 0 |
| ST_WAIT | regulate phase while the startup delay is still running | not in regulation | 0 |
| ST_WATCH | regulate phase after the delay, with no transition and no hold | not in regulation | in regulation |
| ST_FORCED | regulate phase while a transition or its hold is active | 0 | 1 |
| ST_SOFTSTOP | soft-stop phase | 1 | 0 |

The next state depends only on the present phase and the timer flags, so any state can be followed by any other. Three helper units support the state machine: a hold timer, a startup timer and an upper-threshold mask.

Top module: `pg_clken_supervisor`

## Requirements
- R1: While reset is asserted, and after any clock edge at which the phase code is 0 (off), the outputs are `clk_en_n_o`=1 and `pg_release_o`=0.
- R2: After a clock edge at which the phase code is 1 (soft-start) or 4 (soft-stop), the outputs are `clk_en_n_o`=1 and `pg_release_o`=0.
- R3: After a clock edge at which the phase code is 2 (boot), `pg_release_o`=0 and `clk_en_n_o` is the inverse of the in-regulation result sampled at that edge.
- R4: The startup delay counts clock edges. It starts at the first edge at which `clk_en_n_o` is already low after a power-up, and it counts on every edge from then on. It completes at the DELAY_CYC-th edge. Until it has completed, `pg_release_o` can only be released by a transition or its hold. The delay is cleared only by the off phase.
- R5: After a clock edge at which the phase code is 3 (regulate) and `slew_active_i` is 1, the outputs are `clk_en_n_o`=0 and `pg_release_o`=1.
- R6: The forced outputs of R5 remain in place for the HOLD_CYC clock edges that follow the edge at which `slew_active_i` is first sampled low. Any edge at which `slew_active_i` is sampled high reloads the hold, so a transition that starts during the hold restarts it.
- R7: In regulate, once the delay has completed and no transition or hold is active, `pg_release_o` equals the in-regulation result and `clk_en_n_o` is its inverse. The in-regulation result is `win_lo_ok_i` AND (`win_hi_ok_i` OR the upper mask). Whenever `pg_release_o` is 1, `clk_en_n_o` is 0.
- R8: An edge at which `slew_active_i`, `slew_down_i` and `skip_mode_i` are all 1 sets the upper mask. The mask clears at the first edge at which no transition or hold is active and both comparator inputs are 1.
- R9: A transition that is upward (`slew_down_i`=0), or that is downward while `skip_mode_i`=0, leaves the upper mask clear. After such a transition, a low `win_hi_ok_i` takes the block out of regulation.
- R10: Phase codes 5, 6 and 7 are handled exactly like code 0. They also clear the startup delay, the hold and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 3 | Sequencer phase: 0 off, 1 soft-start, 2 boot, 3 regulate, 4 soft-stop |
| slew_active_i | input | 1 | Slew-rate controller is moving the output voltage |
| slew_down_i | input | 1 | The current transition is downward |
| skip_mode_i | input | 1 | The converter is in pulse-skipping mode |
| win_lo_ok_i | input | 1 | Feedback voltage is above the lower window limit |
| win_hi_ok_i | input | 1 | Feedback voltage is below the upper window limit |
| clk_en_n_o | output | 1 | Clock-enable, active low |
| pg_release_o | output | 1 | Power-good pin control: 1 releases the pin, 0 pulls it low |

## Verification
The hardest situation to reach from the ports is a masked upper threshold outliving its transition. This needs three things in order: a downward transition in skip mode, the full hold time, and then `win_hi_ok_i` low while `win_lo_ok_i` stays high. If the two comparators were instead driven high together right after the hold, the mask would clear on that edge and the effect would be hidden. Directed sequences therefore build this order on purpose, and matching sequences show that upward and non-skip transitions leave the mask clear. Constrained random transitions are laid over random comparator values, some of them restarting during the hold. A second power-up checks that the startup delay runs again.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    // Sequencer phase encoding seen on phase_i
    localparam logic [2:0] PH_OFF       = 3'd0;
    localparam logic [2:0] PH_SOFTSTART = 3'd1;
    localparam logic [2:0] PH_BOOT      = 3'd2;
    localparam logic [2:0] PH_REGULATE  = 3'd3;
    localparam logic [2:0] PH_SOFTSTOP  = 3'd4;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SOFTSTART,
        ST_BOOT,
        ST_WAIT,
        ST_WATCH,
        ST_FORCED,
        ST_SOFTSTOP
    } sup_state_e;

    // Codes 5..7 are unused and behave as off (R10)
    function automatic logic phase_is_off(input logic [2:0] ph);
        return !(ph == PH_SOFTSTART || ph == PH_BOOT ||
                 ph == PH_REGULATE  || ph == PH_SOFTSTOP);
    endfunction

endpackage

// File: rtl/pgs_hold_timer.sv
// Forces the outputs while a transition is active and for HOLD_CYC edges after it ends.
module pgs_hold_timer #(
    parameter int unsigned HOLD_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic slew_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (slew_i) begin
            cnt_q <= LOAD;              // restart on every active cycle (R6)
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = slew_i || (cnt_q != '0);

endmodule

// File: rtl/pgs_startup_timer.sv
// Power-good startup delay: starts when clock-enable first goes low, runs once per power-up.
module pgs_startup_timer #(
    parameter int unsigned DELAY_CYC = 625000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic clken_low_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          running;

    assign running = !done_q && ((cnt_q != '0) || clken_low_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (running) begin
            cnt_q  <= cnt_q + 1'b1;
            done_q <= (cnt_q == LAST);
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/pgs_upper_mask.sv
// Upper-threshold blanking after downward transitions in skip mode.
module pgs_upper_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic slew_i,
    input  logic down_i,
    input  logic skip_i,
    input  logic forced_i,
    input  logic lo_ok_i,
    input  logic hi_ok_i,
    output logic mask_o
);
    logic mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (clear_i) begin
            mask_q <= 1'b0;
        end else if (slew_i && down_i && skip_i) begin
            mask_q <= 1'b1;
        end else if (!forced_i && lo_ok_i && hi_ok_i) begin
            mask_q <= 1'b0;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/pg_clken_supervisor.sv
module pg_clken_supervisor
    import pgs_pkg::*;
#(
    parameter int unsigned HOLD_CYC  = 2500,
    parameter int unsigned DELAY_CYC = 625000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase_i,
    input  logic       slew_active_i,
    input  logic       slew_down_i,
    input  logic       skip_mode_i,
    input  logic       win_lo_ok_i,
    input  logic       win_hi_ok_i,
    output logic       clk_en_n_o,
    output logic       pg_release_o
);
    sup_state_e state_q, state_d;
    logic       in_reg_q;
    logic       is_off;
    logic       forced;
    logic       delay_done;
    logic       mask;
    logic       in_reg;

    assign is_off = phase_is_off(phase_i);
    assign in_reg = win_lo_ok_i && (win_hi_ok_i || mask);

    pgs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (is_off),
        .slew_i  (slew_active_i),
        .busy_o  (forced)
    );

    pgs_startup_timer #(.DELAY_CYC(DELAY_CYC)) u_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (is_off),
        .clken_low_i (!clk_en_n_o),
        .done_o      (delay_done)
    );

    pgs_upper_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (is_off),
        .slew_i   (slew_active_i),
        .down_i   (slew_down_i),
        .skip_i   (skip_mode_i),
        .forced_i (forced),
        .lo_ok_i  (win_lo_ok_i),
        .hi_ok_i  (win_hi_ok_i),
        .mask_o   (mask)
    );

    always_comb begin
        unique case (phase_i)
            PH_SOFTSTART: state_d = ST_SOFTSTART;
            PH_BOOT:      state_d = ST_BOOT;
            PH_SOFTSTOP:  state_d = ST_SOFTSTOP;
            PH_REGULATE: begin
                if (forced)           state_d = ST_FORCED;
                else if (!delay_done) state_d = ST_WAIT;
                else                  state_d = ST_WATCH;
            end
            default:      state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            in_reg_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            in_reg_q <= in_reg;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_BOOT, ST_WAIT: begin
                clk_en_n_o   = !in_reg_q;
                pg_release_o = 1'b0;
            end
            ST_WATCH: begin
                clk_en_n_o   = !in_reg_q;
                pg_release_o = in_reg_q;
            end
            ST_FORCED: begin
                clk_en_n_o   = 1'b0;
                pg_release_o = 1'b1;
            end
            default: begin
                clk_en_n_o   = 1'b1;
                pg_release_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
    parameter int unsigned HOLD_CYC = 2500
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase_i,
    input logic       slew_active_i,
    input logic       clk_en_n_o,
    input logic       pg_release_o
);
    p_off_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd0) |=> (clk_en_n_o && !pg_release_o));

    p_ramp_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd1 || phase_i == 3'd4) |=> (clk_en_n_o && !pg_release_o));

    p_boot_pg_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd2) |=> !pg_release_o);

    p_slew_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd3 && slew_active_i) |=> (!clk_en_n_o && pg_release_o));

    p_hold_after_slew_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == 3'd3 && $fell(slew_active_i) && HOLD_CYC > 0)
        |=> (!clk_en_n_o && pg_release_o));

    p_pg_implies_clken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pg_release_o |-> !clk_en_n_o);

    p_unused_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i >= 3'd5) |=> (clk_en_n_o && !pg_release_o));

endmodule

bind pg_clken_supervisor pgs_checker #(.HOLD_CYC(HOLD_CYC)) u_pgs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_i       (phase_i),
    .slew_active_i (slew_active_i),
    .clk_en_n_o    (clk_en_n_o),
    .pg_release_o  (pg_release_o)
);

// File: tb/pg_clken_supervisor_test.sv
`timescale 1ns/1ps
module pg_clken_supervisor_test;
    localparam int HOLD  = 12;
    localparam int DELAY = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] phase = 3'd0;
    logic       slew = 1'b0, down = 1'b0, skip = 1'b0, lo = 1'b0, hi = 1'b0;
    logic       clk_en_n, pg_rel;

    int checks = 0;
    int fails  = 0;
    int force_tag = 0;

    always #4 clk = ~clk;   // 125 MHz

    pg_clken_supervisor #(.HOLD_CYC(HOLD), .DELAY_CYC(DELAY)) uut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase),
        .slew_active_i(slew), .slew_down_i(down), .skip_mode_i(skip),
        .win_lo_ok_i(lo), .win_hi_ok_i(hi),
        .clk_en_n_o(clk_en_n), .pg_release_o(pg_rel)
    );

    // ---------------- reference model built from the requirements ----------------
    int   m_hc, m_dc, e_tag;
    logic m_dd, m_mask, e_ck, e_pg;

    function automatic logic ph_off(input logic [2:0] p);
        return !(p == 3'd1 || p == 3'd2 || p == 3'd3 || p == 3'd4);
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hc <= 0; m_dc <= 0; m_dd <= 1'b0; m_mask <= 1'b0;
            e_ck <= 1'b1; e_pg <= 1'b0; e_tag <= 1;
        end else begin
            logic off, forced, inreg;
            off    = ph_off(phase);
            forced = slew || (m_hc != 0);
            inreg  = lo && (hi || m_mask);
            m_hc   <= off ? 0 : (slew ? HOLD : (m_hc != 0 ? m_hc - 1 : 0));
            if (off)                       m_mask <= 1'b0;
            else if (slew && down && skip) m_mask <= 1'b1;
            else if (!forced && lo && hi)  m_mask <= 1'b0;
            if (off) begin
                m_dc <= 0; m_dd <= 1'b0;
            end else if (!m_dd && (m_dc != 0 || !e_ck)) begin
                m_dc <= m_dc + 1; m_dd <= (m_dc + 1 == DELAY);
            end
            case (phase)
                3'd1, 3'd4: begin e_ck <= 1'b1; e_pg <= 1'b0; e_tag <= 2; end
                3'd2: begin e_ck <= !inreg; e_pg <= 1'b0; e_tag <= 3; end
                3'd3: begin
                    if (forced) begin
                        e_ck <= 1'b0; e_pg <= 1'b1; e_tag <= slew ? 5 : 6;
                    end else if (!m_dd) begin
                        e_ck <= !inreg; e_pg <= 1'b0; e_tag <= 4;
                    end else begin
                        e_ck <= !inreg; e_pg <= inreg; e_tag <= m_mask ? 8 : 7;
                    end
                end
                3'd0: begin e_ck <= 1'b1; e_pg <= 1'b0; e_tag <= 1; end
                default: begin e_ck <= 1'b1; e_pg <= 1'b0; e_tag <= 10; end
            endcase
        end
    end

    task automatic check_now();
        int t;
        t = (force_tag != 0) ? force_tag : e_tag;
        checks++;
        if (clk_en_n !== e_ck || pg_rel !== e_pg) begin
            fails++;
            $display("FAIL %s: clk_en_n=%b pg_release=%b expected clk_en_n=%b pg_release=%b",
                     tag_name(t), clk_en_n, pg_rel, e_ck, e_pg);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic do_slew(input logic dn, input logic sk, input int len);
        slew = 1'b1; down = dn; skip = sk;
        tick(len);
        slew = 1'b0;
    endtask

    task automatic power_up(input int lo_bad_cycles);
        phase = 3'd1; lo = 1'b1; hi = 1'b1;
        tick(5);                                  // R2 soft-start
        phase = 3'd2; lo = 1'b0;
        tick(lo_bad_cycles);                      // R3 boot out of window
        lo = 1'b1;
        tick(6);                                  // R3 boot in window
        phase = 3'd3;
        tick(DELAY + 8);                          // R4 delay, then R7
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick(3);                                  // R1 in reset
        @(negedge clk); rst_n = 1'b1;
        tick(4);                                  // R1 off phase

        power_up(4);

        // R7 window following
        lo = 1'b0; tick(2); lo = 1'b1; hi = 1'b0; tick(2); hi = 1'b1; tick(2);

        // R6 hold, restart within hold
        do_slew(1'b0, 1'b0, 3);
        tick(HOLD / 2);
        do_slew(1'b0, 1'b0, 2);
        tick(HOLD + 3);

        // R9 upward transition in skip mode leaves upper check active
        do_slew(1'b0, 1'b1, 4);
        tick(HOLD);
        force_tag = 9; hi = 1'b0; tick(3); hi = 1'b1; tick(2); force_tag = 0;
        // R9 downward without skip mode
        do_slew(1'b1, 1'b0, 4);
        tick(HOLD);
        force_tag = 9; hi = 1'b0; tick(3); hi = 1'b1; tick(2); force_tag = 0;

        // R8 downward in skip mode: upper masked after hold, cleared on regulation
        hi = 1'b0;
        do_slew(1'b1, 1'b1, 4);
        tick(HOLD);
        force_tag = 8; tick(3);                   // masked: still in regulation
        hi = 1'b1; tick(1);                       // clears mask
        hi = 1'b0; tick(3);                       // now out of regulation
        hi = 1'b1; force_tag = 0; tick(2);

        // constrained random transitions and comparator values
        for (int c = 0; c < 3000; c++) begin
            if (!slew && ($urandom % 30) == 0) begin
                slew = 1'b1; down = $urandom % 2; skip = $urandom % 2;
            end else if (slew && ($urandom % 5) == 0) begin
                slew = 1'b0;
            end
            lo = ($urandom % 8) != 0;
            hi = ($urandom % 6) != 0;
            tick(1);
        end
        slew = 1'b0;

        // R2 soft-stop, R1 off, R10 unused codes
        phase = 3'd4; tick(5);
        phase = 3'd0; tick(4);
        phase = 3'd6; tick(3);
        phase = 3'd7; tick(2);
        phase = 3'd5; tick(2);

        // R4 second power-up: delay runs again
        power_up(8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL R1: watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule